// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Interface Model

This block is a synthesizable, device-side model of a four-input, 8-bit successive-approximation converter as seen from its serial port. A host drives an active-low chip select, a serial clock and a serial data line. The block watches them and runs the track and hold/convert phases in step with the clock. It resolves a result one bit per clock against a digital level given for each input channel, and it shifts that result back out. The analog front end and the comparator are replaced by the per-channel levels on `chanLevels`. The model is meant as a test target for host-side serial controllers.

The serial pins are sampled by a fast system clock, and their edges are found by comparing each sample with the one before. Chip select opens a frame. A frame holds one or more 16-clock slots, and each slot carries one conversion. While a slot is running, the host shifts in a control word that picks the input for the following conversion. When chip select is high, the serial clock is ignored and the data output enable is off.

Top module: `sar_serial_emu`

## Requirements
- R1: In each slot, `tracking` is high during serial clocks 1 to 3 and `converting` is high during clocks 4 to 16. Clock k is the interval that starts at the k-th counted falling edge. Both are low while chip select is high.
- R2: `dout` carries the result most significant bit first during clocks 5 to 12 of a slot. It is 0 during clocks 1 to 4 and 13 to 16, and 0 before the first counted falling edge of a frame.
- R3: Serial clock edges that occur while chip select is high change no output and do not change the channel chosen for the next conversion.
- R4: If the serial clock is low when chip select falls, the fall of chip select counts as falling edge 1, and clock 1 begins at that point.
- R5: If the serial clock is high when chip select falls, clock 1 begins at the first real falling clock edge after that.
- R6: In a frame of several slots, the falling edge after rising edge 16·N starts clock 1 of the next slot. The sequence then repeats, with hold at its fourth falling edge.
- R7: `din` is sampled on rising edges 1 to 8 of each slot to form a control word, most significant bit first. Bits 4:3 of that word (the 4th and 5th bits on the line) give the channel used by the next conversion, either in the next slot or in the next frame. All other bits are ignored.
- R8: `doutOe` is low whenever chip select is high and high whenever it is low, one system clock after the change.
- R9: The result equals the selected channel's level as held at the 4th falling edge of the slot. Later changes of that level do not affect the result.
- R10: The next conversion uses channel 0 after reset. It also uses channel 0 after any frame that ends before 8 control bits of its last slot were received.
- R11: While reset is asserted, `dout`, `doutOe`, `tracking` and `converting` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; frames a transfer |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data from the host |
| chanLevels | input | NUM_CH*DATA_W | Digital level of each input channel, channel 0 in the low bits |
| dout | output | 1 | Serial result data |
| doutOe | output | 1 | Output enable for `dout` (low means high impedance) |
| tracking | output | 1 | High during the track phase of a slot |
| converting | output | 1 | High during the hold/convert phase of a slot |

## Verification
The bench runs frames with the clock parked high and parked low at the fall of chip select. The two cases must land on the same slot timing even though their first falling edge comes from different sources. Frames of one, two and three slots show whether the control word sent in one slot reaches the conversion of the next slot, and whether phase counting restarts correctly after rising edge 16. Two shorter cases test the channel-0 fallback: a frame cut off after six clocks must trigger it, and a frame cut off after exactly eight clocks must not. Clock toggling while deselected, a channel level inverted after the hold edge, and levels of 00, FF, 80 and 01 separate a correct successive approximation from one that samples late or loses its end bits.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;

  // Strobes from the slot sequencer to the datapath, one system clock wide.
  typedef struct packed {
    logic frameEnd;    // chip select rose
    logic partialEnd;  // frame ended before a full control word
    logic slotStart;   // counted falling edge that begins clock 1
    logic holdStart;   // counted falling edge that begins hold
    logic shiftIn;     // rising edge within the control window
    logic commitAddr;  // last control bit arrives
    logic decide;      // rising edge that resolves one result bit
    logic outBit;      // falling edge that presents one result bit
    logic outZero;     // falling edge outside the result window
  } seqStrobe_t;

endpackage

// File: rtl/sar_emu_ctrl.sv
module sar_emu_ctrl
  import sar_emu_pkg::*;
#(
  parameter int SLOT_LEN  = 16,
  parameter int TRACK_LEN = 3,
  parameter int DATA_W    = 8,
  parameter int CTRL_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  output seqStrobe_t strb,
  output logic       tracking,
  output logic       converting
);

  localparam int CNT_W = $clog2(SLOT_LEN + 1);
  localparam logic [CNT_W-1:0] K_ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] K_LAST    = CNT_W'(SLOT_LEN);
  localparam logic [CNT_W-1:0] K_TRK_END = CNT_W'(TRACK_LEN);
  localparam logic [CNT_W-1:0] K_HOLD    = CNT_W'(TRACK_LEN + 1);
  localparam logic [CNT_W-1:0] K_DEC_END = CNT_W'(TRACK_LEN + DATA_W);
  localparam logic [CNT_W-1:0] K_OUT_BEG = CNT_W'(TRACK_LEN + 2);
  localparam logic [CNT_W-1:0] K_OUT_END = CNT_W'(TRACK_LEN + 1 + DATA_W);
  localparam logic [CNT_W-1:0] K_CTRL    = CNT_W'(CTRL_BITS);

  logic             csQ;
  logic             sclkQ;
  logic             riseSeen;
  logic [CNT_W-1:0] fallCnt;
  logic [CNT_W-1:0] nextK;
  logic [CNT_W-1:0] rcvd;
  logic             csFall;
  logic             csRise;
  logic             fallEv;
  logic             riseEv;

  // Edge detection against the previous sample; the clock is gated by select.
  always_comb begin
    csFall = csQ & ~csN;
    csRise = ~csQ & csN;
    // A select fall with the clock parked low acts as the first falling edge.
    fallEv = ~csN & ((csFall & ~sclk) | (~csQ & sclkQ & ~sclk));
    riseEv = ~csN & ~csQ & ~sclkQ & sclk;
    nextK  = (fallCnt == K_LAST || fallCnt == '0) ? K_ONE : fallCnt + K_ONE;
    rcvd   = (fallCnt == '0) ? '0 : fallCnt - K_ONE + CNT_W'(riseSeen);
  end

  always_comb begin
    strb            = '0;
    strb.frameEnd   = csRise;
    strb.partialEnd = csRise & (rcvd < K_CTRL);
    strb.slotStart  = fallEv & (nextK == K_ONE);
    strb.holdStart  = fallEv & (nextK == K_HOLD);
    strb.shiftIn    = riseEv & (fallCnt >= K_ONE) & (fallCnt <= K_CTRL);
    strb.commitAddr = riseEv & (fallCnt == K_CTRL);
    strb.decide     = riseEv & (fallCnt >= K_HOLD) & (fallCnt <= K_DEC_END);
    strb.outBit     = fallEv & (nextK >= K_OUT_BEG) & (nextK <= K_OUT_END);
    strb.outZero    = fallEv & ~((nextK >= K_OUT_BEG) & (nextK <= K_OUT_END));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ      <= 1'b1;
      sclkQ    <= 1'b0;
      fallCnt  <= '0;
      riseSeen <= 1'b0;
    end else begin
      csQ   <= csN;
      sclkQ <= sclk;
      if (csN) begin
        fallCnt  <= '0;
        riseSeen <= 1'b0;
      end else if (fallEv) begin
        fallCnt  <= nextK;
        riseSeen <= 1'b0;
      end else if (riseEv) begin
        riseSeen <= 1'b1;
      end
    end
  end

  assign tracking   = (fallCnt >= K_ONE) && (fallCnt <= K_TRK_END);
  assign converting = (fallCnt >= K_HOLD);

  // R5
  rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEv |-> (fallCnt != '0));

  // R3
  track_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tracking) |-> !$past(csN));

endmodule

// File: rtl/sar_emu_datapath.sv
module sar_emu_datapath
  import sar_emu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int CTRL_BITS = 8,
  parameter int ADDR_LSB  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     din,
  input  logic [NUM_CH*DATA_W-1:0] chanLevels,
  input  seqStrobe_t               strb,
  output logic                     dout,
  output logic                     doutOe
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int PTR_W = $clog2(DATA_W);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DATA_W - 1);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic [DATA_W-1:0]    lvl [NUM_CH];
  logic [CTRL_BITS-1:0] ctrlSh;
  logic [CTRL_BITS-1:0] ctrlNext;
  logic [CH_W-1:0]      nextCh;
  logic [CH_W-1:0]      curCh;
  logic [DATA_W-1:0]    sample;
  logic [DATA_W-1:0]    sarReg;
  logic [DATA_W-1:0]    trial;
  logic [PTR_W-1:0]     decPtr;
  logic [PTR_W-1:0]     outPtr;
  logic                 doutQ;
  logic                 oeQ;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
      assign lvl[c] = chanLevels[c*DATA_W +: DATA_W];
    end
  endgenerate

  assign ctrlNext = {ctrlSh[CTRL_BITS-2:0], din};
  assign trial    = sarReg | (DATA_W'(1) << decPtr);

  // Control word and channel selection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlSh <= '0;
      nextCh <= '0;
      curCh  <= '0;
    end else begin
      if (strb.shiftIn) ctrlSh <= ctrlNext;
      if (strb.commitAddr) nextCh <= ctrlNext[ADDR_LSB +: CH_W];
      else if (strb.partialEnd) nextCh <= '0;
      if (strb.slotStart) curCh <= nextCh;
    end
  end

  // Hold sample and bit-serial approximation, one bit per rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sample <= '0;
      sarReg <= '0;
      decPtr <= PTR_TOP;
    end else if (strb.holdStart) begin
      sample <= lvl[curCh];
      sarReg <= '0;
      decPtr <= PTR_TOP;
    end else if (strb.decide) begin
      if (sample >= trial) sarReg <= trial;
      decPtr <= decPtr - PTR_ONE;
    end
  end

  // Output shifter, updated on counted falling edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutQ  <= 1'b0;
      outPtr <= PTR_TOP;
      oeQ    <= 1'b0;
    end else begin
      oeQ <= ~csN;
      if (strb.frameEnd || strb.outZero) begin
        doutQ <= 1'b0;
        if (strb.holdStart) outPtr <= PTR_TOP;
      end else if (strb.outBit) begin
        doutQ  <= sarReg[outPtr];
        outPtr <= outPtr - PTR_ONE;
      end
    end
  end

  assign dout   = doutQ;
  assign doutOe = oeQ;

  // R9
  sar_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sarReg <= sample);

endmodule

// File: rtl/sar_serial_emu.sv
module sar_serial_emu
  import sar_emu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int SLOT_LEN  = 16,
  parameter int TRACK_LEN = 3,
  parameter int CTRL_BITS = 8,
  parameter int ADDR_LSB  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     din,
  input  logic [NUM_CH*DATA_W-1:0] chanLevels,
  output logic                     dout,
  output logic                     doutOe,
  output logic                     tracking,
  output logic                     converting
);

  seqStrobe_t strb;

  sar_emu_ctrl #(
    .SLOT_LEN (SLOT_LEN),
    .TRACK_LEN(TRACK_LEN),
    .DATA_W   (DATA_W),
    .CTRL_BITS(CTRL_BITS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .strb      (strb),
    .tracking  (tracking),
    .converting(converting)
  );

  sar_emu_datapath #(
    .DATA_W   (DATA_W),
    .NUM_CH   (NUM_CH),
    .CTRL_BITS(CTRL_BITS),
    .ADDR_LSB (ADDR_LSB)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .din       (din),
    .chanLevels(chanLevels),
    .strb      (strb),
    .dout      (dout),
    .doutOe    (doutOe)
  );

  // R2
  quiet_in_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    tracking |-> !dout);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doutOe |-> !dout);

endmodule

// File: tb/sar_serial_emu_tb.sv
module sar_serial_emu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [7:0]  lvl [4];
  logic [31:0] chanLevels;
  logic        dout, doutOe, tracking, converting;

  int total = 0;
  int bad = 0;
  bit running = 0;

  // behavioural reference state
  int         k = 0;
  int         nextCh = 0;
  int         curCh = 0;
  bit         seenRise = 0;
  logic [7:0] samp = '0;
  logic [7:0] ctrlW = '0;
  logic [7:0] cap = '0;
  bit         expDout = 0, expOe = 0, expTrack = 0, expConv = 0;
  string      curTag = "";

  always #2 clk = ~clk;

  assign chanLevels = {lvl[3], lvl[2], lvl[1], lvl[0]};

  sar_serial_emu dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .chanLevels(chanLevels), .dout(dout), .doutOe(doutOe),
    .tracking(tracking), .converting(converting)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkByte(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s result act=%02h exp=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      chk("R1 tracking", tracking, expTrack);
      chk("R1 converting", converting, expConv);
      chk("R2 dout", dout, expDout);
      chk("R8 doutOe", doutOe, expOe);
    end
  end

  function automatic void modelFall();
    k = (k == 16 || k == 0) ? 1 : k + 1;
    seenRise = 0;
    if (k == 1) curCh = nextCh;
    if (k == 4) samp = lvl[curCh];
    expDout  = (k >= 5 && k <= 12) ? samp[12-k] : 1'b0;
    expTrack = (k >= 1 && k <= 3);
    expConv  = (k >= 4);
  endfunction

  function automatic void modelRise(input logic d);
    seenRise = 1;
    if (k >= 1 && k <= 8) begin
      ctrlW = {ctrlW[6:0], d};
      if (k == 8) nextCh = int'(ctrlW[4:3]);
    end
  endfunction

  function automatic void modelCsRise();
    int rcvd;
    rcvd = (k == 0) ? 0 : k - 1 + int'(seenRise);
    if (rcvd < 8) nextCh = 0;
    k = 0; seenRise = 0;
    expDout = 0; expOe = 0; expTrack = 0; expConv = 0;
  endfunction

  task automatic gap();
    repeat (2) @(posedge clk);
  endtask

  task automatic csLow();
    @(negedge clk) csN = 1'b0;
    @(posedge clk); #1;
    expOe = 1;
    if (!sclk) modelFall();
    gap();
  endtask

  task automatic csHigh();
    @(negedge clk) csN = 1'b1;
    @(posedge clk); #1;
    modelCsRise();
    gap();
  endtask

  task automatic sFall();
    @(negedge clk) sclk = 1'b0;
    @(posedge clk); #1;
    if (!csN) modelFall();
    gap();
  endtask

  task automatic sRise(input logic d);
    @(negedge clk);
    if (!csN && k >= 5 && k <= 12) begin
      cap = {cap[6:0], dout};
      if (k == 12) chkByte(curTag, cap, samp);
    end
    din = d; sclk = 1'b1;
    @(posedge clk); #1;
    if (!csN) modelRise(d);
    gap();
  endtask

  task automatic runFrame(input bit parkLow, input int nClk, input logic [7:0] cw0,
                          input logic [7:0] cw1, input logic [7:0] cw2,
                          input bit disturb, input string tag);
    curTag = tag;
    @(negedge clk) sclk = parkLow ? 1'b0 : 1'b1;
    gap();
    csLow();
    for (int i = 0; i < nClk; i++) begin
      int kk;
      logic [7:0] cw;
      if (!(i == 0 && parkLow)) sFall();
      if (disturb && k == 6) lvl[curCh] = ~lvl[curCh];
      kk = (i % 16) + 1;
      cw = (i / 16 == 0) ? cw0 : ((i / 16 == 1) ? cw1 : cw2);
      sRise((kk <= 8) ? cw[8-kk] : 1'b0);
    end
    csHigh();
    if (parkLow) begin
      @(negedge clk) sclk = 1'b0;
      gap();
    end
  endtask

  function automatic logic [7:0] sel(input int ch);
    return 8'(ch << 3) | 8'b1000_0100;  // stray bits outside 4:3 must be ignored (R7)
  endfunction

  initial begin
    lvl[0] = 8'hA5; lvl[1] = 8'h3C; lvl[2] = 8'hFF; lvl[3] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 dout", dout, 1'b0);
    chk("R11 doutOe", doutOe, 1'b0);
    chk("R11 tracking", tracking, 1'b0);
    chk("R11 converting", converting, 1'b0);
    @(negedge clk) rstN = 1'b1;
    gap();
    running = 1;
    // R5 parked high; R10 first conversion uses channel 0
    runFrame(1'b0, 16, sel(2), 8'h00, 8'h00, 1'b0, "R5 R10 first frame");
    // R4 parked low, R6 two slots, R7 address carried across slots
    runFrame(1'b1, 32, sel(1), sel(3), 8'h00, 1'b0, "R4 R6 R7 two slots");
    // R9 level changes after hold are ignored
    runFrame(1'b0, 16, sel(0), 8'h00, 8'h00, 1'b1, "R9 held level");
    // R10 partial frame of 6 clocks drops selection of channel 2
    lvl[0] = 8'h80;
    runFrame(1'b1, 6, sel(2), 8'h00, 8'h00, 1'b0, "R10 partial");
    runFrame(1'b0, 16, sel(1), 8'h00, 8'h00, 1'b0, "R10 after partial");
    // R3 clock toggles while deselected
    lvl[1] = 8'h01;
    for (int j = 0; j < 5; j++) begin
      sFall();
      sRise(1'b1);
    end
    runFrame(1'b1, 16, sel(3), 8'h00, 8'h00, 1'b0, "R3 after idle toggles");
    // exactly eight control bits keep the selection (R10 boundary)
    runFrame(1'b0, 8, sel(2), 8'h00, 8'h00, 1'b0, "R10 eight bits");
    lvl[2] = 8'h7E; lvl[3] = 8'hC3;
    runFrame(1'b1, 48, sel(3), sel(0), sel(1), 1'b0, "R6 R7 three slots");
    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule